// File: doc/BRIEF.md
# Power-of-Two Resolution Watchdog Timer

This block is a memory-mapped watchdog timer. A down-counter runs at a tick rate set by a small resolution field, and a fixed slow reference pulse drives that rate. Software writes one control word that holds the reload count, the resolution, a counter enable and a reset enable. It reads the ticks that remain from a second, read-only word. When an enabled count runs out with the reset enable set, the block pulses a system-reset output.

A new count does not reach the counter at once. A fixed number of clock cycles models the transfer into the slower counting domain. During that time a busy flag in the control word reads as 1 and the counter holds its value. Software keeps the watchdog alive by writing a count field that differs from the stored one. Each such write restarts the load. A write that leaves the count field unchanged updates only the mode bits.

Top module: `pow2_wdog`

## Requirements
- R1: Reset state. The control word reads 0x0040_0000, which is resolution 4 with all other fields zero. The count word reads 0 and `sys_rst_o` is low.
- R2: Control word layout at address 0x0. Bits 19:0 hold the reload count, bits 23:20 the resolution, bit 26 the reset enable, bit 27 the counter enable and bit 28 the busy flag. Bits 31:29, 25 and 24 always read 0.
- R3: A control write whose count field differs from the stored one sets the busy flag for LOAD_CYC cycles, starting in the cycle after the write. The counter holds during that time. In the cycle after busy clears, the counter holds the new count.
- R4: With the counter enabled, it decrements by one every 2^(15-resolution) reference pulses, counted from the end of the load. It never goes below zero.
- R5: Only clock cycles in which `ref_tick_i` is high advance the tick divider. Gaps between reference pulses stretch the tick period in proportion.
- R6: When the counter steps from 1 to 0 with the reset enable set, `sys_rst_o` is high for exactly one cycle, namely the cycle in which the count first reads 0. The counter then stays at 0 until it is reloaded.
- R7: With the reset enable clear, the counter stops at 0 and `sys_rst_o` stays low.
- R8: While the counter enable is 0, the count holds regardless of reference pulses.
- R9: A control write with an unchanged count field does not set busy and does not reload the counter. A changed count field reloads the counter, which is the keep-alive.
- R10: The count word at address 0x4 returns the remaining ticks in bits 19:0. Bits 31:20 read 0.
- R11: Writes to address 0x4 have no effect on the counter or on the control fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick_i | input | 1 | Reference pulse enable, nominally 32768 per second |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| sys_rst_o | output | 1 | One-cycle system reset request on expiry |

## Verification
The bench sweeps the resolutions with the shortest dividers and follows the count cycle by cycle against an arithmetic model. A divider off by one, or a divider that does not restart at the load, shows up as a count that changes one cycle early or late. Sparse reference patterns catch a divider that counts clock cycles in place of reference pulses. The expiry tests catch a reset pulse that lasts two cycles, that fires with the reset enable clear, or that lets the counter wrap below zero. The load tests check that busy lasts exactly LOAD_CYC cycles and that the counter does not move during it. They also check that an unchanged count field and a write to the count address leave the counter untouched, and that clearing the enable freezes the count.

// File: rtl/pow2_wdog_pkg.sv
`timescale 1ns/1ps
package pow2_wdog_pkg;
   localparam int unsigned REG_W      = 32;
   localparam int unsigned CTRL_ADDR  = 0;
   localparam int unsigned COUNT_ADDR = 4;
   localparam int unsigned RES_LSB    = 20;
   localparam int unsigned RSTEN_BIT  = 26;
   localparam int unsigned RUN_BIT    = 27;
   localparam int unsigned BUSY_BIT   = 28;

   typedef enum logic [1:0] {
      SEL_CTRL  = 2'd0,
      SEL_COUNT = 2'd1,
      SEL_NONE  = 2'd2
   } reg_sel_e;
endpackage

// File: rtl/pow2_wdog_regs.sv
`timescale 1ns/1ps
module pow2_wdog_regs
   import pow2_wdog_pkg::*;
#(
   parameter int unsigned CNT_W   = 20,
   parameter int unsigned RES_W   = 4,
   parameter int unsigned RES_RST = 4,
   parameter int unsigned ADDR_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [REG_W-1:0]  wdata_i,
   input  logic [CNT_W-1:0]  count_i,
   input  logic              busy_i,
   output logic              run_en_o,
   output logic              rst_en_o,
   output logic [RES_W-1:0]  res_o,
   output logic [CNT_W-1:0]  reload_o,
   output logic              cnt_wr_o,
   output logic [REG_W-1:0]  rdata_o
);
   reg_sel_e   sel;
   logic       wr_ctrl;
   logic       unused_wbits;

   always_comb begin
      if (addr_i == ADDR_W'(CTRL_ADDR))       sel = SEL_CTRL;
      else if (addr_i == ADDR_W'(COUNT_ADDR)) sel = SEL_COUNT;
      else                                    sel = SEL_NONE;
   end

   assign wr_ctrl      = wr_en_i && (sel == SEL_CTRL);
   assign cnt_wr_o     = wr_ctrl && (wdata_i[CNT_W-1:0] != reload_o);
   assign unused_wbits = ^wdata_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_en_o <= 1'b0;
         rst_en_o <= 1'b0;
         res_o    <= RES_W'(RES_RST);
         reload_o <= '0;
      end else if (wr_ctrl) begin
         run_en_o <= wdata_i[RUN_BIT];
         rst_en_o <= wdata_i[RSTEN_BIT];
         res_o    <= wdata_i[RES_LSB +: RES_W];
         reload_o <= wdata_i[CNT_W-1:0];
      end
   end

   always_comb begin
      rdata_o = '0;
      unique case (sel)
         SEL_CTRL: begin
            rdata_o[CNT_W-1:0]         = reload_o;
            rdata_o[RES_LSB +: RES_W]  = res_o;
            rdata_o[RSTEN_BIT]         = rst_en_o;
            rdata_o[RUN_BIT]           = run_en_o;
            rdata_o[BUSY_BIT]          = busy_i;
         end
         SEL_COUNT: rdata_o[CNT_W-1:0] = count_i;
         default:   rdata_o            = '0;
      endcase
   end
endmodule

// File: rtl/pow2_wdog_loader.sv
`timescale 1ns/1ps
module pow2_wdog_loader #(
   parameter int unsigned LOAD_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o,
   output logic load_go_o
);
   generate
      if (LOAD_CYC == 0) begin : g_direct
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign busy_o     = 1'b0;
         assign load_go_o  = start_i;
      end else begin : g_delay
         localparam int unsigned BW = $clog2(LOAD_CYC + 1);
         logic [BW-1:0] left_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              left_q <= '0;
            else if (start_i)        left_q <= BW'(LOAD_CYC);
            else if (left_q != '0)   left_q <= left_q - 1'b1;
         end

         assign busy_o    = (left_q != '0);
         assign load_go_o = (left_q == BW'(1)) && !start_i;
      end
   endgenerate
endmodule

// File: rtl/pow2_wdog_prescale.sv
`timescale 1ns/1ps
module pow2_wdog_prescale #(
   parameter int unsigned RES_W    = 4,
   parameter int unsigned REF_LOG2 = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             clear_i,
   input  logic             ref_i,
   input  logic [RES_W-1:0] res_i,
   output logic             tick_o
);
   localparam int unsigned SH_W = $clog2(REF_LOG2 + 1);

   logic [REF_LOG2-1:0] pres_q;
   logic [SH_W-1:0]     shamt;
   logic [REF_LOG2:0]   span;
   logic [REF_LOG2:0]   last;

   assign shamt  = SH_W'(REF_LOG2) - SH_W'(res_i);
   assign span   = (REF_LOG2+1)'(1) << shamt;
   assign last   = span - 1'b1;
   assign tick_o = run_i && ref_i && ({1'b0, pres_q} >= last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                pres_q <= '0;
      else if (clear_i || !run_i) pres_q <= '0;
      else if (ref_i)            pres_q <= tick_o ? '0 : pres_q + 1'b1;
   end
endmodule

// File: rtl/pow2_wdog_counter.sv
`timescale 1ns/1ps
module pow2_wdog_counter #(
   parameter int unsigned CNT_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_go_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             tick_i,
   input  logic             rst_en_i,
   output logic [CNT_W-1:0] count_o,
   output logic             expire_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_o  <= '0;
         expire_o <= 1'b0;
      end else begin
         expire_o <= 1'b0;
         if (load_go_i) begin
            count_o <= load_val_i;
         end else if (tick_i && (count_o != '0)) begin
            count_o <= count_o - 1'b1;
            if ((count_o == CNT_W'(1)) && rst_en_i) expire_o <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/pow2_wdog.sv
`timescale 1ns/1ps
module pow2_wdog
   import pow2_wdog_pkg::*;
#(
   parameter int unsigned CNT_W    = 20,
   parameter int unsigned RES_W    = 4,
   parameter int unsigned RES_RST  = 4,
   parameter int unsigned REF_LOG2 = 15,
   parameter int unsigned LOAD_CYC = 4,
   parameter int unsigned ADDR_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_tick_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [31:0]       wdata_i,
   output logic [31:0]       rdata_o,
   output logic              sys_rst_o
);
   localparam int unsigned RES_MAX = (1 << RES_W) - 1;

   initial begin
      if (CNT_W < 1 || CNT_W > RES_LSB)
         $error("pow2_wdog: CNT_W must be 1..%0d", RES_LSB);
      if (RES_W < 1 || RES_W > 4)
         $error("pow2_wdog: RES_W must be 1..4");
      if (RES_MAX > REF_LOG2)
         $error("pow2_wdog: largest resolution exceeds REF_LOG2");
      if (RES_RST > RES_MAX)
         $error("pow2_wdog: RES_RST out of range");
      if (ADDR_W < 3)
         $error("pow2_wdog: ADDR_W too narrow for the count address");
   end

   logic             run_en;
   logic             rst_en;
   logic [RES_W-1:0] res;
   logic [CNT_W-1:0] reload;
   logic [CNT_W-1:0] load_val;
   logic [CNT_W-1:0] cnt;
   logic             cnt_wr;
   logic             busy;
   logic             load_go;
   logic             tick;

   pow2_wdog_regs #(
      .CNT_W(CNT_W), .RES_W(RES_W), .RES_RST(RES_RST), .ADDR_W(ADDR_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
      .wdata_i(wdata_i), .count_i(cnt), .busy_i(busy),
      .run_en_o(run_en), .rst_en_o(rst_en), .res_o(res),
      .reload_o(reload), .cnt_wr_o(cnt_wr), .rdata_o(rdata_o)
   );

   pow2_wdog_loader #(.LOAD_CYC(LOAD_CYC)) u_load (
      .clk(clk), .rst_n(rst_n), .start_i(cnt_wr),
      .busy_o(busy), .load_go_o(load_go)
   );

   generate
      if (LOAD_CYC == 0) begin : g_val_direct
         assign load_val = wdata_i[CNT_W-1:0];
      end else begin : g_val_reg
         assign load_val = reload;
      end
   endgenerate

   pow2_wdog_prescale #(.RES_W(RES_W), .REF_LOG2(REF_LOG2)) u_pres (
      .clk(clk), .rst_n(rst_n), .run_i(run_en && !busy), .clear_i(load_go),
      .ref_i(ref_tick_i), .res_i(res), .tick_o(tick)
   );

   pow2_wdog_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load_go_i(load_go), .load_val_i(load_val),
      .tick_i(tick), .rst_en_i(rst_en), .count_o(cnt), .expire_o(sys_rst_o)
   );
endmodule

// File: rtl/pow2_wdog_chk.sv
`timescale 1ns/1ps
module pow2_wdog_chk #(
   parameter int unsigned CNT_W = 20
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy,
   input logic             load_go,
   input logic             run_en,
   input logic             rst_en,
   input logic [CNT_W-1:0] cnt,
   input logic             sys_rst_o,
   input logic [31:0]      rdata_o
);
   p_busy_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (busy -> $stable(cnt)));

   p_step_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(load_go) && (cnt != $past(cnt)))
      |-> (cnt == $past(cnt) - 1'b1));

   p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst_o |=> !sys_rst_o);

   p_pulse_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst_o |-> (cnt == '0));

   p_no_pulse_wo_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst_o |-> $past(rst_en));

   p_frozen_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en && !load_go) |=> $stable(cnt));

   p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata_o[31:29] == 3'b000) && (rdata_o[25:24] == 2'b00));
endmodule

bind pow2_wdog pow2_wdog_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .load_go(load_go),
   .run_en(run_en), .rst_en(rst_en), .cnt(cnt),
   .sys_rst_o(sys_rst_o), .rdata_o(rdata_o)
);

// File: tb/pow2_wdog_tb.sv
`timescale 1ns/1ps
module pow2_wdog_tb;
   localparam int LOAD_CYC = 4;
   localparam logic [3:0] A_CTRL = 4'h0;
   localparam logic [3:0] A_CNT  = 4'h4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ref_tick = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  addr = A_CNT;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        sys_rst;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #4 clk = ~clk;

   pow2_wdog #(.LOAD_CYC(LOAD_CYC)) u_dut (
      .clk(clk), .rst_n(rst_n), .ref_tick_i(ref_tick), .wr_en_i(wr_en),
      .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .sys_rst_o(sys_rst)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] v);
      addr = a;
      #1;
      v = rdata;
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; addr = A_CNT;
   endtask

   function automatic logic [31:0] ctrl_word(input bit en, input bit rsten,
                                            input int res, input int cnt);
      return (32'(en) << 27) | (32'(rsten) << 26) | (32'(res) << 20) | 32'(cnt);
   endfunction

   // Write a new count and follow the load, then the count-down, against a model.
   task automatic run_cfg(input string req, input int res, input int reload,
                          input bit rsten, input int period);
      logic [31:0] v, c0;
      int d, refs, mism, pulses, exp_cnt;
      bit pat, exp_rst;
      d = 1 << (15 - res);
      ref_tick = 1'b0;
      wr(A_CTRL, ctrl_word(1'b1, rsten, res, reload));
      rd(A_CNT, c0);
      mism = 0;
      for (int k = 0; k < LOAD_CYC; k++) begin
         rd(A_CTRL, v);
         if (v[28] !== 1'b1) mism++;
         rd(A_CNT, v);
         if (v !== c0) mism++;
         @(negedge clk);
      end
      chk("R3 busy window and hold", 32'(mism), 32'd0);
      rd(A_CTRL, v);
      chk("R3 busy clear after load", {31'd0, v[28]}, 32'd0);
      rd(A_CNT, v);
      chk("R3 count loaded", v, 32'(reload));
      refs = 0; mism = 0; pulses = 0;
      for (int n = 1; n <= reload * d * period + 4; n++) begin
         pat = ((n % period) == 0);
         ref_tick = pat;
         @(negedge clk);
         if (pat) refs++;
         exp_cnt = (refs / d >= reload) ? 0 : reload - refs / d;
         exp_rst = rsten && pat && (refs == reload * d);
         rd(A_CNT, v);
         if (v !== 32'(exp_cnt)) begin
            if (mism == 0)
               $display("  %s trace at n=%0d: count=%0d model=%0d", req, n, v, exp_cnt);
            mism++;
         end
         if (sys_rst !== exp_rst) mism++;
         if (sys_rst) pulses++;
      end
      ref_tick = 1'b0;
      chk(req, 32'(mism), 32'd0);
      if (rsten) chk("R6 single reset pulse", 32'(pulses), 32'd1);
      else       chk("R7 no reset pulse", 32'(pulses), 32'd0);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v, held;
      int mism;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(A_CTRL, v); chk("R1 ctrl reset", v, 32'h0040_0000);
      rd(A_CNT, v);  chk("R1 count reset", v, 32'h0);
      chk("R1 reset output low", {31'd0, sys_rst}, 32'd0);

      // R2 layout and reserved bits, R10 count word
      wr(A_CTRL, 32'hFFFF_FFFF);
      rd(A_CTRL, v); chk("R2 readback while busy", v, 32'h1CFF_FFFF);
      repeat (LOAD_CYC) @(negedge clk);
      rd(A_CTRL, v); chk("R2 readback idle", v, 32'h0CFF_FFFF);
      rd(A_CNT, v);  chk("R10 count word", v, 32'h000F_FFFF);

      // R8 and R9: stop with unchanged count field
      wr(A_CTRL, 32'h000F_FFFF);
      rd(A_CTRL, v); chk("R9 same count no busy", v, 32'h000F_FFFF);
      ref_tick = 1'b1;
      mism = 0;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         rd(A_CNT, v);
         if (v !== 32'h000F_FFFF) mism++;
      end
      chk("R8 count frozen when disabled", 32'(mism), 32'd0);
      ref_tick = 1'b0;

      // R11 writes to the count address are ignored
      wr(A_CNT, 32'hFFFF_FFFF);
      rd(A_CTRL, v); chk("R11 ctrl untouched", v, 32'h000F_FFFF);
      wr(A_CNT, 32'h0000_0003);
      repeat (LOAD_CYC + 1) @(negedge clk);
      rd(A_CNT, v);  chk("R11 count untouched", v, 32'h000F_FFFF);

      // R4 divider sweep, R6 expiry with reset enable
      run_cfg("R4 res15", 15, 3, 1'b1, 1);
      run_cfg("R4 res14", 14, 4, 1'b1, 1);
      run_cfg("R4 res13", 13, 5, 1'b1, 1);
      run_cfg("R4 res12", 12, 6, 1'b1, 1);
      // R5 sparse reference pulses, R7 without reset enable
      run_cfg("R5 res14 every3", 14, 4, 1'b0, 3);
      run_cfg("R5 res15 every2", 15, 7, 1'b1, 2);
      rd(A_CNT, v); chk("R6 stays at zero", v, 32'h0);

      // R9 keep-alive
      wr(A_CTRL, ctrl_word(1'b1, 1'b1, 15, 20));
      repeat (LOAD_CYC) @(negedge clk);
      ref_tick = 1'b1;
      repeat (5) @(negedge clk);
      rd(A_CNT, v); chk("R4 running before keep-alive", v, 32'd15);
      wr(A_CTRL, ctrl_word(1'b1, 1'b1, 15, 20));
      rd(A_CTRL, v); chk("R9 unchanged count no busy", {31'd0, v[28]}, 32'd0);
      rd(A_CNT, v);  chk("R9 unchanged count no reload", v, 32'd13);
      wr(A_CTRL, ctrl_word(1'b1, 1'b1, 15, 21));
      rd(A_CNT, held);
      rd(A_CTRL, v); chk("R9 keep-alive busy", {31'd0, v[28]}, 32'd1);
      repeat (LOAD_CYC - 1) @(negedge clk);
      rd(A_CNT, v);  chk("R3 held during load", v, held);
      @(negedge clk);
      rd(A_CNT, v);  chk("R9 keep-alive reload", v, 32'd21);
      ref_tick = 1'b0;
      wr(A_CTRL, ctrl_word(1'b0, 1'b0, 15, 21));

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule